// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of independent ownership tokens that two agents, a left port and a right port, use to agree on who may touch a shared resource. Each port has a select strobe, a token index, a write strobe, one data bit and a data output bus. When select and write are both high, the port writes its data bit: a 0 asks for the token and a 1 gives it up. When select is high and write is low, the port reads the token. A token that is already owned is not taken away. A request that arrives while the other side holds the token stays pending, and the token passes to that requester as soon as the holder gives it up.

A read returns 0 when the reading port owns the indexed token and 1 otherwise. That bit is copied onto every line of the port's output bus. The bus is registered: it changes in the cycle after the read strobe and keeps its value until the same port reads again. If both ports ask for the same free token in one cycle, the hardware settles it in that cycle. The left port wins and the right port's request stays pending.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous active-high reset, every token is free, no request is pending, and both output buses are all ones.
- R2: A port that writes 0 (sel=1, wr=1, din=0) to a free token owns it from the next cycle. Its reads of that token then return 0, and reads by the other port return 1. The two ports never own the same token at once.
- R3: A write of 0 to a token the other port owns does not change the owner. The requesting port keeps reading 1 and its request becomes pending.
- R4: A holder that writes 1 to its token releases it. If the other port has a pending request, the other port owns the token from the next cycle and reads 0.
- R5: A port with a pending request that writes 1 to that token withdraws the request. A later release then leaves the token free.
- R6: When both ports write 0 to the same free token in one cycle, the left port is granted and the right port's request becomes pending.
- R7: A read (sel=1, wr=0) places the token value on all DW output bits in the next cycle. The value reflects the token state before any write made in the same cycle.
- R8: A port's output bus keeps its value until that port issues its next read. Writes and the other port's activity do not change it.
- R9: Each index addresses its own token. Operations on one index leave all other tokens unchanged.
- R10: A holder writing 0 again has no effect. A port writing 1 to a token it neither holds nor requests has no effect.
- R11: If one port releases a token in the same cycle that the other port writes 0 to it, the requester owns the token from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left port semaphore select |
| l_idx | input | IDX_W | Left port token index |
| l_wr | input | 1 | Left port write strobe (1 write, 0 read) |
| l_din | input | 1 | Left port write bit (0 request, 1 release) |
| l_dout | output | DW | Left port registered read value, replicated |
| r_sel | input | 1 | Right port semaphore select |
| r_idx | input | IDX_W | Right port token index |
| r_wr | input | 1 | Right port write strobe (1 write, 0 read) |
| r_din | input | 1 | Right port write bit (0 request, 1 release) |
| r_dout | output | DW | Right port registered read value, replicated |

## Verification
The two ports can act on the same token in the same cycle in three ways. Both can request a free token. One can release while the other requests. One can read while the other writes. The bench drives each of these collisions on purpose, and also repeats the same operation on different indices to show that tokens do not disturb each other. A behavioural model in the bench works out the owner and the pending requests cycle by cycle, and it computes each read value from the state before that edge. The bench compares both output buses with this model on every clock.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  // Ownership state of one token
  typedef enum logic [1:0] {
    TOK_FREE  = 2'd0,
    TOK_LEFT  = 2'd1,
    TOK_RIGHT = 2'd2
  } tok_owner_e;

  // Decoded write action of one port toward one token
  typedef struct packed {
    logic take;  // write of 0
    logic give;  // write of 1
  } tok_op_t;

endpackage

// File: rtl/sem_cell.sv
module sem_cell
  import sem_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  tok_op_t l_op,
  input  tok_op_t r_op,
  output logic    held_l,
  output logic    held_r
);

  tok_owner_e owner_q, owner_d;
  logic       wait_l_q, wait_l_d;
  logic       wait_r_q, wait_r_d;
  logic       keep_l, keep_r;

  always_comb begin
    // releases first
    keep_l = (owner_q == TOK_LEFT)  && !l_op.give;
    keep_r = (owner_q == TOK_RIGHT) && !r_op.give;
    // pending requests: a give withdraws, a take by a non-holder registers
    wait_l_d = (wait_l_q && !l_op.give) || (l_op.take && owner_q != TOK_LEFT);
    wait_r_d = (wait_r_q && !r_op.give) || (r_op.take && owner_q != TOK_RIGHT);
    owner_d  = keep_l ? TOK_LEFT : (keep_r ? TOK_RIGHT : TOK_FREE);
    // grant a free token, left side first
    if (owner_d == TOK_FREE) begin
      if (wait_l_d) begin
        owner_d  = TOK_LEFT;
        wait_l_d = 1'b0;
      end else if (wait_r_d) begin
        owner_d  = TOK_RIGHT;
        wait_r_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= TOK_FREE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      wait_l_q <= wait_l_d;
      wait_r_q <= wait_r_d;
    end
  end

  assign held_l = (owner_q == TOK_LEFT);
  assign held_r = (owner_q == TOK_RIGHT);

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_SEM = 8,
  parameter int DW      = 9,
  localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] held,
  output logic [DW-1:0]      dout
);

  logic rd_bit;

  assign rd_bit = ~held[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '1;
    end else if (sel && !wr) begin
      dout <= {DW{rd_bit}};
    end
  end

endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_bank_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DW      = 9,
  localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_sel,
  input  logic [IDX_W-1:0] l_idx,
  input  logic             l_wr,
  input  logic             l_din,
  output logic [DW-1:0]    l_dout,
  input  logic             r_sel,
  input  logic [IDX_W-1:0] r_idx,
  input  logic             r_wr,
  input  logic             r_din,
  output logic [DW-1:0]    r_dout
);

  logic [NUM_SEM-1:0] held_l;
  logic [NUM_SEM-1:0] held_r;
  tok_op_t            l_op [NUM_SEM];
  tok_op_t            r_op [NUM_SEM];

  for (genvar k = 0; k < NUM_SEM; k++) begin : g_tok
    logic l_hit, r_hit;
    assign l_hit = l_sel && l_wr && (l_idx == IDX_W'(k));
    assign r_hit = r_sel && r_wr && (r_idx == IDX_W'(k));
    assign l_op[k].take = l_hit && !l_din;
    assign l_op[k].give = l_hit &&  l_din;
    assign r_op[k].take = r_hit && !r_din;
    assign r_op[k].give = r_hit &&  r_din;

    sem_cell i_cell (
      .clk    (clk),
      .rst    (rst),
      .l_op   (l_op[k]),
      .r_op   (r_op[k]),
      .held_l (held_l[k]),
      .held_r (held_r[k])
    );
  end

  sem_read_port #(.NUM_SEM(NUM_SEM), .DW(DW)) i_rd_l (
    .clk  (clk),
    .rst  (rst),
    .sel  (l_sel),
    .wr   (l_wr),
    .idx  (l_idx),
    .held (held_l),
    .dout (l_dout)
  );

  sem_read_port #(.NUM_SEM(NUM_SEM), .DW(DW)) i_rd_r (
    .clk  (clk),
    .rst  (rst),
    .sel  (r_sel),
    .wr   (r_wr),
    .idx  (r_idx),
    .held (held_r),
    .dout (r_dout)
  );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DW      = 9,
  localparam int IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               l_sel,
  input logic [IDX_W-1:0]   l_idx,
  input logic               l_wr,
  input logic               l_din,
  input logic [DW-1:0]      l_dout,
  input logic               r_sel,
  input logic [IDX_W-1:0]   r_idx,
  input logic               r_wr,
  input logic               r_din,
  input logic [DW-1:0]      r_dout,
  input logic [NUM_SEM-1:0] held_l,
  input logic [NUM_SEM-1:0] held_r
);

  // R2
  exclusive_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (held_l & held_r) == '0);

  // R7
  l_uniform_read_chk: assert property (@(posedge clk) disable iff (rst)
    (l_sel && !l_wr) |=> (l_dout == '0 || l_dout == '1));

  // R7
  r_uniform_read_chk: assert property (@(posedge clk) disable iff (rst)
    (r_sel && !r_wr) |=> (r_dout == '0 || r_dout == '1));

  // R7
  l_owned_read_chk: assert property (@(posedge clk) disable iff (rst)
    (l_sel && !l_wr && held_l[l_idx]) |=> (l_dout == '0));

  // R8
  l_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_sel && !l_wr) |=> $stable(l_dout));

  // R8
  r_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(r_sel && !r_wr) |=> $stable(r_dout));

  for (genvar k = 0; k < NUM_SEM; k++) begin : g_k
    logic lt, lg, rt, rg;
    assign lt = l_sel && l_wr && !l_din && (l_idx == IDX_W'(k));
    assign lg = l_sel && l_wr &&  l_din && (l_idx == IDX_W'(k));
    assign rt = r_sel && r_wr && !r_din && (r_idx == IDX_W'(k));
    assign rg = r_sel && r_wr &&  r_din && (r_idx == IDX_W'(k));

    // R2 R6
    free_grant_left_chk: assert property (@(posedge clk) disable iff (rst)
      (!held_l[k] && !held_r[k] && lt) |=> held_l[k]);

    // R3
    blocked_left_chk: assert property (@(posedge clk) disable iff (rst)
      (held_r[k] && lt && !rg) |=> !held_l[k]);

    // R3
    blocked_right_chk: assert property (@(posedge clk) disable iff (rst)
      (held_l[k] && rt && !lg) |=> !held_r[k]);

    // R4
    release_left_chk: assert property (@(posedge clk) disable iff (rst)
      (held_l[k] && lg) |=> !held_l[k]);

    // R11
    handover_right_chk: assert property (@(posedge clk) disable iff (rst)
      (held_l[k] && lg && rt) |=> held_r[k]);
  end

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DW(DW)) i_sem_bank_chk (
  .clk    (clk),
  .rst    (rst),
  .l_sel  (l_sel),
  .l_idx  (l_idx),
  .l_wr   (l_wr),
  .l_din  (l_din),
  .l_dout (l_dout),
  .r_sel  (r_sel),
  .r_idx  (r_idx),
  .r_wr   (r_wr),
  .r_din  (r_din),
  .r_dout (r_dout),
  .held_l (held_l),
  .held_r (held_r)
);

// File: tb/test_sem_bank.sv
module test_sem_bank;
  localparam int NS = 8;
  localparam int DW = 9;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_wr = 0, l_din = 0, r_sel = 0, r_wr = 0, r_din = 0;
  logic [IW-1:0] l_idx = '0, r_idx = '0;
  logic [DW-1:0] l_dout, r_dout;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference: 0 free, 1 left, 2 right
  int own [NS];
  bit pl [NS];
  bit pr [NS];
  logic [DW-1:0] el, er;

  always #10 clk = ~clk;  // 50 MHz

  sem_bank #(.NUM_SEM(NS), .DW(DW)) i_sem_bank (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_idx(l_idx), .l_wr(l_wr), .l_din(l_din), .l_dout(l_dout),
    .r_sel(r_sel), .r_idx(r_idx), .r_wr(r_wr), .r_din(r_din), .r_dout(r_dout)
  );

  task automatic compare();
    checks++;
    if (l_dout !== el) begin
      failures++;
      $display("FAIL %s left dout actual=%h expected=%h", tag, l_dout, el);
    end
    checks++;
    if (r_dout !== er) begin
      failures++;
      $display("FAIL %s right dout actual=%h expected=%h", tag, r_dout, er);
    end
  endtask

  task automatic model_edge();
    int li, ri;
    li = int'(l_idx);
    ri = int'(r_idx);
    if (l_sel && !l_wr) el = (own[li] == 1) ? '0 : '1;
    if (r_sel && !r_wr) er = (own[ri] == 2) ? '0 : '1;
    if (l_sel && l_wr && l_din) begin
      if (own[li] == 1) own[li] = 0;
      pl[li] = 0;
    end
    if (r_sel && r_wr && r_din) begin
      if (own[ri] == 2) own[ri] = 0;
      pr[ri] = 0;
    end
    if (l_sel && l_wr && !l_din && own[li] != 1) pl[li] = 1;
    if (r_sel && r_wr && !r_din && own[ri] != 2) pr[ri] = 1;
    for (int k = 0; k < NS; k++) begin
      if (own[k] == 0) begin
        if (pl[k]) begin own[k] = 1; pl[k] = 0; end
        else if (pr[k]) begin own[k] = 2; pr[k] = 0; end
      end
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit ls, input int li, input bit lw, input bit ld,
                     input bit rs, input int ri, input bit rw, input bit rd);
    l_sel = ls; l_idx = IW'(li); l_wr = lw; l_din = ld;
    r_sel = rs; r_idx = IW'(ri); r_wr = rw; r_din = rd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic read_both(input int li, input int ri);
    cyc(1, li, 0, 0, 1, ri, 0, 0);
  endtask

  task automatic read_all();
    for (int k = 0; k < NS; k++) read_both(k, k);
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin own[k] = 0; pl[k] = 0; pr[k] = 0; end
    el = '1; er = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    compare();
    read_all();

    tag = "R2";
    cyc(1, 2, 1, 0, 0, 0, 0, 0);
    read_both(2, 2);

    tag = "R3";
    cyc(0, 0, 0, 0, 1, 2, 1, 0);
    read_both(2, 2);

    tag = "R10";
    cyc(1, 2, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 6, 1, 1);
    read_both(2, 6);

    tag = "R4";
    cyc(1, 2, 1, 1, 0, 0, 0, 0);
    read_both(2, 2);

    tag = "R6";
    cyc(1, 5, 1, 0, 1, 5, 1, 0);
    read_both(5, 5);
    cyc(1, 5, 1, 1, 0, 0, 0, 0);
    read_both(5, 5);

    tag = "R5";
    cyc(1, 1, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 1, 1, 1);
    cyc(1, 1, 1, 1, 0, 0, 0, 0);
    read_both(1, 1);

    tag = "R11";
    cyc(0, 0, 0, 0, 1, 3, 1, 0);
    cyc(1, 3, 1, 0, 1, 3, 1, 1);
    read_both(3, 3);

    tag = "R7";
    cyc(1, 4, 0, 0, 1, 4, 1, 0);
    read_both(4, 4);
    cyc(1, 4, 1, 0, 1, 4, 0, 0);
    read_both(4, 4);
    cyc(0, 0, 0, 0, 1, 4, 1, 1);
    cyc(1, 4, 0, 0, 0, 0, 0, 0);

    tag = "R8";
    read_both(3, 5);
    idle();
    cyc(1, 0, 1, 0, 1, 7, 1, 0);
    idle();
    cyc(1, 0, 1, 1, 0, 0, 0, 0);
    idle();

    tag = "R9";
    read_all();
    for (int k = 0; k < NS; k++) cyc(k[0], k, 1, 0, !k[0], k, 1, 0);
    read_all();
    for (int k = 0; k < NS; k++) cyc(1, k, 1, 1, 1, k, 1, 1);
    read_all();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule